// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block holds the 64-bit multiply-accumulate register of a 32-bit processor core, seen by software as two 32-bit halves: a high half (bits 63:32) and a low half (bits 31:0). The core's decode stage presents one operation per strobe, together with two 32-bit register operands and the current saturation mode flag. The block computes the product, combines it with the accumulator according to the selected operation, and registers the result. The result is visible on the two read ports one clock after the strobe. Memory operand fetch and pointer updates stay in the core's load/store path. The two operand values arrive here already read.

The operations are a low-half 32-bit multiply, unsigned and signed 16-bit multiplies, unsigned and signed 32x32 full multiplies, and accumulate forms for long (32-bit) and word (16-bit) operands. With the saturation flag set, long accumulation works in a signed 48-bit window held in the low 48 bits of the register. Word accumulation then clamps to the signed 32-bit range in the low half and records an overflow in bit 0 of the high half. The core can also load either half directly from a register value.

Top module: `mac_accum`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both halves read zero.
- R2: The code on op_sel is taken when op_valid is high, and its result appears on mach_o/macl_o on the next clock. In a cycle with op_valid, wr_hi and wr_lo all low, both halves hold their value.
- R3: op_sel 0 (low multiply) writes bits 31:0 of opa*opb to the low half. The high half is left unchanged.
- R4: op_sel 1 multiplies opa[15:0] by opb[15:0], both zero-extended. op_sel 2 does the same with both sign-extended. Each writes the 32-bit product to the low half only and leaves the high half unchanged.
- R5: op_sel 3 writes the unsigned 64-bit product of opa and opb to the whole register. op_sel 4 writes the signed 64-bit product.
- R6: op_sel 5 (long accumulate) with sat_en low adds the signed 64-bit product of opa and opb to the register, modulo 2^64.
- R7: op_sel 5 with sat_en high takes bits 47:0 of the register as a signed value and adds the signed product. It clamps the sum to the range -2^47 to 2^47-1 and writes that result to bits 47:0. Bits 63:48 are unchanged.
- R8: op_sel 6 (word accumulate) with sat_en low adds the sign-extended signed product of opa[15:0] and opb[15:0] to the whole register, modulo 2^64.
- R9: op_sel 6 with sat_en high adds that product to the low half, taken as signed. If the sum lies outside the signed 32-bit range, the low half becomes 0x7FFFFFFF for positive overflow or 0x80000000 for negative overflow, and bit 0 of the high half is set. If the sum is in range, the low half takes the sum and the high half is unchanged.
- R10: With op_valid low, wr_hi loads wr_data into bits 63:32 and wr_lo loads wr_data into bits 31:0. Each leaves the other half unchanged, and both may act in the same cycle.
- R11: op_sel 7 changes nothing. When op_valid is high, wr_hi and wr_lo are ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation code (see R3 to R11) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| sat_en | input | 1 | Saturation mode flag |
| wr_hi | input | 1 | Load high half from wr_data |
| wr_lo | input | 1 | Load low half from wr_data |
| wr_data | input | 32 | Value for half loads |
| mach_o | output | 32 | High half, bits 63:32 |
| macl_o | output | 32 | Low half, bits 31:0 |

## Verification
The bench preloads the accumulator with distinct nonzero patterns before each operation. A multiply that wrongly touches the high half is therefore seen, and so is an accumulate that reads the wrong extension of the stored value. It crosses every operation code and both saturation settings with operands at the sign boundaries (0x80000000, 0x7FFFFFFF, 0xFFFFFFFF, 0x8000). A 16-bit form that sign-extends where it should zero-extend, or the reverse, returns a different low half on those operands. Targeted cases then push the 48-bit window past both limits with nonzero bits 63:48. They also push the low half across both 32-bit limits. A design that clamped the full 64 bits, cleared the upper 16 bits, or missed the overflow mark in bit 0 of the high half would read back a wrong value. The last cases strobe an operation together with half writes, to show that the writes are dropped.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_MUL32  = 3'd0,
        OP_MULU16 = 3'd1,
        OP_MULS16 = 3'd2,
        OP_DMULU  = 3'd3,
        OP_DMULS  = 3'd4,
        OP_MACL   = 3'd5,
        OP_MACW   = 3'd6,
        OP_NONE   = 3'd7
    } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
// Product generator: picks the product form each operation needs,
// extended to the accumulator width.
module mac_mult
    import mac_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  mac_op_e           op,
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    output logic [2*DW-1:0]   prod
);
    localparam int unsigned AW = 2 * DW;
    localparam int unsigned HW = DW / 2;

    logic [AW-1:0] a_zx, b_zx, a_sx, b_sx;
    logic [AW-1:0] ah_zx, bh_zx, ah_sx, bh_sx;
    logic [AW-1:0] full_u, full_s, half_u, half_s;

    always_comb begin
        a_zx  = {{DW{1'b0}}, a};
        b_zx  = {{DW{1'b0}}, b};
        a_sx  = {{DW{a[DW-1]}}, a};
        b_sx  = {{DW{b[DW-1]}}, b};
        ah_zx = {{(AW-HW){1'b0}}, a[HW-1:0]};
        bh_zx = {{(AW-HW){1'b0}}, b[HW-1:0]};
        ah_sx = {{(AW-HW){a[HW-1]}}, a[HW-1:0]};
        bh_sx = {{(AW-HW){b[HW-1]}}, b[HW-1:0]};
        // Truncating a product of two sign-extended values to AW bits
        // yields the two's complement signed product.
        full_u = a_zx * b_zx;
        full_s = a_sx * b_sx;
        half_u = ah_zx * bh_zx;
        half_s = ah_sx * bh_sx;
    end

    always_comb begin
        unique case (op)
            OP_MUL32, OP_DMULU: prod = full_u;
            OP_DMULS, OP_MACL:  prod = full_s;
            OP_MULU16:          prod = half_u;
            OP_MULS16, OP_MACW: prod = half_s;
            default:            prod = '0;
        endcase
    end

endmodule

// File: rtl/mac_sat_long.sv
// Long accumulate: plain wide add, or a signed SW-bit window clamp
// that keeps the bits above the window.
module mac_sat_long #(
    parameter int unsigned DW = 32,
    parameter int unsigned SW = 48
) (
    input  logic [2*DW-1:0] acc,
    input  logic [2*DW-1:0] prod,
    input  logic            sat_en,
    output logic [2*DW-1:0] res
);
    localparam int unsigned AW = 2 * DW;
    localparam logic [AW-1:0] WIN_MAX = {{(AW-SW+1){1'b0}}, {(SW-1){1'b1}}};
    localparam logic [AW-1:0] WIN_MIN = ~WIN_MAX;

    logic [AW-1:0] win_ext;
    logic [AW-1:0] win_sum;
    logic [AW-1:0] win_clamp;

    always_comb begin
        win_ext = {{(AW-SW){acc[SW-1]}}, acc[SW-1:0]};
        win_sum = win_ext + prod;
        if ($signed(win_sum) > $signed(WIN_MAX)) begin
            win_clamp = WIN_MAX;
        end else if ($signed(win_sum) < $signed(WIN_MIN)) begin
            win_clamp = WIN_MIN;
        end else begin
            win_clamp = win_sum;
        end
        if (sat_en) begin
            res = {acc[AW-1:SW], win_clamp[SW-1:0]};
        end else begin
            res = acc + prod;
        end
    end

endmodule

// File: rtl/mac_sat_word.sv
// Word accumulate: plain wide add, or a signed DW-bit clamp in the low
// half with an overflow mark in bit 0 of the high half.
module mac_sat_word #(
    parameter int unsigned DW = 32
) (
    input  logic [2*DW-1:0] acc,
    input  logic [2*DW-1:0] prod,
    input  logic            sat_en,
    output logic [2*DW-1:0] res
);
    localparam int unsigned AW = 2 * DW;

    logic [DW:0]   lo_sum;
    logic          lo_ovf;
    logic [DW-1:0] lo_clamp;
    logic [DW-1:0] hi_mark;

    always_comb begin
        lo_sum   = {acc[DW-1], acc[DW-1:0]} + prod[DW:0];
        lo_ovf   = lo_sum[DW] ^ lo_sum[DW-1];
        lo_clamp = lo_sum[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        hi_mark  = acc[AW-1:DW] | {{(DW-1){1'b0}}, 1'b1};
        if (!sat_en) begin
            res = acc + prod;
        end else if (lo_ovf) begin
            res = {hi_mark, lo_clamp};
        end else begin
            res = {acc[AW-1:DW], lo_sum[DW-1:0]};
        end
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned SW = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [OP_W-1:0]     op_sel,
    input  logic [DW-1:0]       opa,
    input  logic [DW-1:0]       opb,
    input  logic                sat_en,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [DW-1:0]       wr_data,
    output logic [DW-1:0]       mach_o,
    output logic [DW-1:0]       macl_o
);
    localparam int unsigned AW = 2 * DW;

    typedef struct packed {
        logic [AW-1:0] acc;
    } mac_state_t;

    mac_state_t    state_d, state_q;
    mac_op_e       op;
    logic [AW-1:0] prod;
    logic [AW-1:0] long_res;
    logic [AW-1:0] word_res;

    assign op = mac_op_e'(op_sel);

    mac_mult #(.DW(DW)) mult_i (
        .op   (op),
        .a    (opa),
        .b    (opb),
        .prod (prod)
    );

    mac_sat_long #(.DW(DW), .SW(SW)) long_i (
        .acc    (state_q.acc),
        .prod   (prod),
        .sat_en (sat_en),
        .res    (long_res)
    );

    mac_sat_word #(.DW(DW)) word_i (
        .acc    (state_q.acc),
        .prod   (prod),
        .sat_en (sat_en),
        .res    (word_res)
    );

    always_comb begin
        state_d = state_q;
        if (op_valid) begin
            unique case (op)
                OP_MUL32, OP_MULU16, OP_MULS16: state_d.acc[DW-1:0] = prod[DW-1:0];
                OP_DMULU, OP_DMULS:             state_d.acc = prod;
                OP_MACL:                        state_d.acc = long_res;
                OP_MACW:                        state_d.acc = word_res;
                default:                        state_d = state_q;
            endcase
        end else begin
            if (wr_hi) state_d.acc[AW-1:DW] = wr_data;
            if (wr_lo) state_d.acc[DW-1:0]  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mach_o = state_q.acc[AW-1:DW];
    assign macl_o = state_q.acc[DW-1:0];

endmodule

// File: rtl/mac_accum_chk.sv
module mac_accum_chk
    import mac_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [OP_W-1:0] op_sel,
    input logic            sat_en,
    input logic            wr_hi,
    input logic            wr_lo,
    input logic [DW-1:0]   wr_data,
    input logic [DW-1:0]   mach_o,
    input logic [DW-1:0]   macl_o
);

    // R1: first edge after reset release sees a cleared register
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mach_o == '0 && macl_o == '0));

    // R2: no strobe and no write keeps both halves
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !wr_hi && !wr_lo) |=> ($stable(mach_o) && $stable(macl_o)));

    // R3, R4: low-half multiplies never touch the high half
    a_r4_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 3'd0 || op_sel == 3'd1 || op_sel == 3'd2))
        |=> $stable(mach_o));

    // R7: saturating long accumulate keeps bits 63:48
    a_r7_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd5 && sat_en)
        |=> (mach_o[DW-1:DW/2] == $past(mach_o[DW-1:DW/2])));

    // R10: a lone high-half write loads it and leaves the low half
    a_r10_write_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && wr_hi && !wr_lo)
        |=> (mach_o == $past(wr_data) && $stable(macl_o)));

    // R11: the spare code changes nothing, even with writes requested
    a_r11_spare_code: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd7) |=> ($stable(mach_o) && $stable(macl_o)));

endmodule

bind mac_accum mac_accum_chk #(.DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .sat_en   (sat_en),
    .wr_hi    (wr_hi),
    .wr_lo    (wr_lo),
    .wr_data  (wr_data),
    .mach_o   (mach_o),
    .macl_o   (macl_o)
);

// File: tb/mac_accum_tb_top.sv
module mac_accum_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        sat_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic        wr_lo = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] mach_o;
    logic [31:0] macl_o;

    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    logic [63:0] model_acc = '0;

    always #4 clk = ~clk;

    mac_accum dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_sel   (op_sel),
        .opa      (opa),
        .opb      (opb),
        .sat_en   (sat_en),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .wr_data  (wr_data),
        .mach_o   (mach_o),
        .macl_o   (macl_o)
    );

    function automatic logic [63:0] model(input logic [63:0] m, input logic [2:0] op,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic s);
        logic [63:0] r;
        longint      p;
        longint      sum;
        int          ha;
        int          hb;
        r  = m;
        ha = int'(shortint'(a[15:0]));
        hb = int'(shortint'(b[15:0]));
        case (op)
            3'd0: r[31:0] = a * b;
            3'd1: r[31:0] = {16'b0, a[15:0]} * {16'b0, b[15:0]};
            3'd2: r[31:0] = 32'(ha * hb);
            3'd3: r = {32'b0, a} * {32'b0, b};
            3'd4: r = 64'(longint'(int'(a)) * longint'(int'(b)));
            3'd5: begin
                p = longint'(int'(a)) * longint'(int'(b));
                if (!s) begin
                    r = m + 64'(p);
                end else begin
                    sum = longint'({{16{m[47]}}, m[47:0]}) + p;
                    if (sum > 64'sh00007FFFFFFFFFFF) sum = 64'sh00007FFFFFFFFFFF;
                    if (sum < -64'sh0000800000000000) sum = -64'sh0000800000000000;
                    r = {m[63:48], sum[47:0]};
                end
            end
            3'd6: begin
                p = longint'(ha * hb);
                if (!s) begin
                    r = m + 64'(p);
                end else begin
                    sum = longint'(int'(m[31:0])) + p;
                    if (sum > 64'sd2147483647) begin
                        r[31:0] = 32'h7FFFFFFF;
                        r[32]   = 1'b1;
                    end else if (sum < -64'sd2147483648) begin
                        r[31:0] = 32'h80000000;
                        r[32]   = 1'b1;
                    end else begin
                        r[31:0] = sum[31:0];
                    end
                end
            end
            default: r = m;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic s);
        case (op)
            3'd0:    return "R3";
            3'd1:    return "R4";
            3'd2:    return "R4";
            3'd3:    return "R5";
            3'd4:    return "R5";
            3'd5:    return s ? "R7" : "R6";
            3'd6:    return s ? "R9" : "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] exp);
        checks++;
        if ({mach_o, macl_o} !== exp) begin
            fails++;
            $display("FAIL %s: actual %h_%h expected %h_%h", tag, mach_o, macl_o,
                     exp[63:32], exp[31:0]);
        end
    endtask

    task automatic load(input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        wr_hi = 1'b1;
        wr_data = hi;
        @(negedge clk);
        wr_hi = 1'b0;
        wr_lo = 1'b1;
        wr_data = lo;
        @(negedge clk);
        wr_lo = 1'b0;
        model_acc = {hi, lo};
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic s, input string tag);
        @(negedge clk);
        op_valid = 1'b1;
        op_sel = op;
        opa = a;
        opb = b;
        sat_en = s;
        @(negedge clk);
        op_valid = 1'b0;
        model_acc = model(model_acc, op, a, b, s);
        check(tag, model_acc);
    endtask

    localparam int NV = 8;
    logic [31:0] vals [NV] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000,
                               32'h7FFFFFFF, 32'h00008000, 32'h0001FFFF, 32'h12345678};

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        #2;
        check("R1", 64'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", 64'h0);
        @(negedge clk);
        check("R1", 64'h0);

        // R10: separate and combined half writes
        @(negedge clk);
        wr_hi = 1'b1;
        wr_data = 32'hA5A5_0001;
        @(negedge clk);
        wr_hi = 1'b0;
        check("R10", {32'hA5A5_0001, 32'h0});
        wr_lo = 1'b1;
        wr_data = 32'h0BAD_F00D;
        @(negedge clk);
        wr_lo = 1'b0;
        check("R10", {32'hA5A5_0001, 32'h0BAD_F00D});
        wr_hi = 1'b1;
        wr_lo = 1'b1;
        wr_data = 32'h1357_9BDF;
        @(negedge clk);
        wr_hi = 1'b0;
        wr_lo = 1'b0;
        model_acc = {32'h1357_9BDF, 32'h1357_9BDF};
        check("R10", model_acc);

        // R2: idle cycles hold, and the result appears one cycle after the strobe
        @(negedge clk);
        check("R2", model_acc);
        @(negedge clk);
        op_valid = 1'b1;
        op_sel = 3'd3;
        opa = 32'h0000_0003;
        opb = 32'h0000_0005;
        #2;
        check("R2", model_acc);
        @(negedge clk);
        op_valid = 1'b0;
        model_acc = 64'd15;
        check("R2", model_acc);

        // Sweep: every code, both flag settings, boundary operand pairs
        for (int s = 0; s < 2; s++) begin
            for (int op = 0; op < 8; op++) begin
                for (int i = 0; i < NV; i++) begin
                    for (int j = 0; j < NV; j++) begin
                        load(vals[j] ^ 32'h5A00_0000, vals[i] ^ vals[(i + j) % NV]);
                        run_op(3'(op), vals[i], vals[j], 1'(s), tag_of(3'(op), 1'(s)));
                    end
                end
            end
        end

        // R7: positive and negative clamps of the 48-bit window, top bits kept
        load(32'hABCD_7FFF, 32'hFFFF_FFF0);
        run_op(3'd5, 32'h0000_0100, 32'h0000_0001, 1'b1, "R7");
        check("R7", 64'hABCD_7FFF_FFFF_FFFF);
        load(32'h1234_8000, 32'h0000_0010);
        run_op(3'd5, 32'hFFFF_FF00, 32'h0000_0001, 1'b1, "R7");
        check("R7", 64'h1234_8000_0000_0000);
        // R6: the same case with the flag clear wraps across bit 48
        load(32'hABCD_7FFF, 32'hFFFF_FFF0);
        run_op(3'd5, 32'h0000_0100, 32'h0000_0001, 1'b0, "R6");
        check("R6", 64'hABCD_8000_0000_00F0);

        // R9: low-half clamps with the overflow mark, and an in-range sum
        load(32'h0000_0000, 32'h7FFF_FFF0);
        run_op(3'd6, 32'h0000_0010, 32'h0000_0010, 1'b1, "R9");
        check("R9", 64'h0000_0001_7FFF_FFFF);
        load(32'hF0F0_F0F0, 32'h8000_0004);
        run_op(3'd6, 32'h0000_FFFF, 32'h0000_0010, 1'b1, "R9");
        check("R9", 64'hF0F0_F0F1_8000_0000);
        load(32'h0000_0002, 32'h0000_0004);
        run_op(3'd6, 32'h0000_FFFF, 32'h0000_0010, 1'b1, "R9");
        check("R9", 64'h0000_0002_FFFF_FFF4);
        // R8: wide add carries into the high half
        load(32'h0000_0002, 32'hFFFF_FFFF);
        run_op(3'd6, 32'h0000_0001, 32'h0000_0001, 1'b0, "R8");
        check("R8", 64'h0000_0003_0000_0000);

        // R11: strobe with half writes drops the writes
        load(32'h1111_1111, 32'h2222_2222);
        @(negedge clk);
        op_valid = 1'b1;
        op_sel = 3'd0;
        opa = 32'h0000_0007;
        opb = 32'h0000_0006;
        wr_hi = 1'b1;
        wr_lo = 1'b1;
        wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        op_valid = 1'b0;
        op_sel = 3'd7;
        check("R11", 64'h1111_1111_0000_002A);
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        wr_hi = 1'b0;
        wr_lo = 1'b0;
        check("R11", 64'h1111_1111_0000_002A);

        finish_run();
    end

endmodule